// File: doc/BRIEF.md
# Linear Wrapping Burst Address Generator

This block is the synchronous read-burst front end of a word-addressed memory of 1,048,576 words of 16 bits. The host gives a starting word address and pulls an active-low load strobe low for one edge of the burst clock. The block captures that address and drives it to the internal array. Each later edge with the active-low advance strobe low moves it on by one word. The step wraps inside the aligned 32-word window that holds the starting address, so a burst can run for as long as the host keeps advancing, and it repeats the same window until a new address is loaded.

The array is a behavioural read-only model with a registered read port. The word at the current address appears one clock after the edge that set that address. Chip-enable and output-enable, both active low, gate the data outputs. When either is high, the block drops its pad-drive flag and forces the data bus to zero, so a wrapper can put the pads into high impedance. Read data has no flow control. The block never back-pressures, and a host that needs time between words holds the advance strobe high.

Top module: `burst_reader`

## Requirements
- R1: After reset, `burst_addr` is 0 and `rd_data` is 0.
- R2: On a rising clock edge with `load_n` low, `burst_addr` takes the value of `start_addr`. The new value is visible after that edge.
- R3: On a rising edge with `load_n` high and `adv_n` low, bits 4:0 of `burst_addr` increase by one and roll over from 31 to 0.
- R4: While `load_n` is high, bits 19:5 of `burst_addr` never change, including at the 31-to-0 rollover.
- R5: When `load_n` and `adv_n` are both low on the same edge, the load wins. `burst_addr` becomes `start_addr` and is not incremented.
- R6: On an edge with both strobes high, `burst_addr` holds its value.
- R7: Bit k of the array word at address A equals A[k] for bits 15:4. Bits 3:0 equal A[3:0] XOR A[19:16]. `rd_data` shows the word for `burst_addr` one clock after the edge that set that address, provided the output is enabled.
- R8: `rd_oe` is 1 exactly when `ce_n` and `oe_n` are both low. Otherwise `rd_oe` is 0 and `rd_data` is 0.
- R9: A burst continues without limit. After 64 advances from a loaded address, `burst_addr` equals that address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Load starting address, active low, sampled on clk |
| adv_n | input | 1 | Advance to next word, active low, sampled on clk |
| start_addr | input | 20 | Starting word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_addr | output | 20 | Current array word address |
| rd_data | output | 16 | Read data, zero when not driven |
| rd_oe | output | 1 | Pad drive enable for rd_data |

## Verification
Load and advance can fall on the same clock edge. The bench provokes this by pulling both strobes low for one edge, with the current address at a mid-window value and a different start address on the bus. It judges the result by requiring `burst_addr` to equal the new start address exactly, not that address plus one. It then requires the following read word to match that address. The rollover of the low five bits can also coincide with a pending change of the upper bits. This case is covered by advancing across 31 and checking that bits 19:5 stay put.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned WIN_W  = 5;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_ADV  = 2'd2
  } step_e;
endpackage

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned WW = WIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] addr
);
  localparam int unsigned HI_W = AW - WW;

  step_e           step;
  logic [WW-1:0]   low_nxt;
  logic [HI_W-1:0] hi_q;
  logic [WW-1:0]   low_q;

  // load outranks advance
  always_comb begin
    if (!load_n)     step = STEP_LOAD;
    else if (!adv_n) step = STEP_ADV;
    else             step = STEP_HOLD;
  end

  assign low_nxt = low_q + {{(WW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      low_q <= '0;
    end else begin
      case (step)
        STEP_LOAD: begin
          hi_q  <= start_addr[AW-1:WW];
          low_q <= start_addr[WW-1:0];
        end
        STEP_ADV: low_q <= low_nxt;
        default: ;
      endcase
    end
  end

  assign addr = {hi_q, low_q};

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> addr == $past(start_addr));

  a_r3_low_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !adv_n) |=> addr[WW-1:0] == WW'($past(addr[WW-1:0]) + 1'b1));

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(addr[AW-1:WW]));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && adv_n) |=> $stable(addr));
endmodule

// File: rtl/burst_array_model.sv
module burst_array_model
  import burst_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rd_q
);
  localparam int unsigned XW = (AW > DW) ? (AW - DW) : 0;

  logic [DW-1:0] word;

  generate
    if (XW > 0) begin : g_fold
      localparam int unsigned FW = (XW < DW) ? XW : DW;
      logic [DW-1:0] fold;
      assign fold = {{(DW-FW){1'b0}}, addr[DW +: FW]};
      assign word = addr[DW-1:0] ^ fold;
    end else begin : g_plain
      assign word = DW'(addr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= word;
  end
endmodule

// File: rtl/burst_out_gate.sv
module burst_out_gate
  import burst_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          drive
);
  assign drive = ~(ce_n | oe_n);
  assign dout  = drive ? din : '0;

  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (dout == '0));

  a_r8_drive_pass: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (dout == din));
endmodule

// File: rtl/burst_reader.sv
module burst_reader
  import burst_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  logic          ce_n,
  input  logic          oe_n,
  output logic [AW-1:0] burst_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);
  logic [DW-1:0] arr_q;

  burst_addr_seq #(.AW(AW), .WW(WW)) i_seq (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .adv_n(adv_n),
    .start_addr(start_addr), .addr(burst_addr)
  );

  burst_array_model #(.AW(AW), .DW(DW)) i_arr (
    .clk(clk), .rst_n(rst_n), .addr(burst_addr), .rd_q(arr_q)
  );

  burst_out_gate #(.DW(DW)) i_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .din(arr_q), .dout(rd_data), .drive(rd_oe)
  );

  // R5: a load on the same edge as an advance lands on the start address
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !adv_n) |=> burst_addr == $past(start_addr));
endmodule

// File: tb/test_burst_reader.sv
module test_burst_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        adv_n = 1'b1;
  logic [19:0] start_addr = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [19:0] burst_addr;
  logic [15:0] rd_data;
  logic        rd_oe;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  burst_reader i_burst_reader (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .adv_n(adv_n),
    .start_addr(start_addr), .ce_n(ce_n), .oe_n(oe_n),
    .burst_addr(burst_addr), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  function automatic logic [15:0] word_of(input logic [19:0] a);
    return {a[15:4], a[3:0] ^ a[19:16]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at the falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic ld, input logic av, input logic [19:0] a);
    load_n = ld; adv_n = av; start_addr = a;
    @(posedge clk);
    @(negedge clk);
    load_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 addr", 32'(burst_addr), 32'h0);
    chk("R1 data", 32'(rd_data), 32'h0);
  endtask

  task automatic t_load;
    ce_n = 1'b0; oe_n = 1'b0;
    step(1'b0, 1'b1, 20'hA_BC4D);
    chk("R2 load", 32'(burst_addr), 32'hABC4D);
    step(1'b1, 1'b1, 20'h0);
    chk("R7 data", 32'(rd_data), 32'(word_of(20'hABC4D)));
    chk("R6 hold", 32'(burst_addr), 32'hABC4D);
  endtask

  task automatic t_wrap;
    step(1'b0, 1'b1, 20'h3_579E);
    step(1'b1, 1'b0, 20'h0);
    chk("R3 step", 32'(burst_addr), 32'h3579F);
    chk("R7 lag", 32'(rd_data), 32'(word_of(20'h3579E)));
    step(1'b1, 1'b0, 20'h0);
    chk("R3 wrap", 32'(burst_addr), 32'h35780);
    chk("R4 upper", 32'(burst_addr[19:5]), 32'(20'h35780 >> 5));
    step(1'b1, 1'b1, 20'h0);
    chk("R7 after wrap", 32'(rd_data), 32'(word_of(20'h35780)));
  endtask

  task automatic t_priority;
    step(1'b0, 1'b1, 20'h0_1230);
    step(1'b0, 1'b0, 20'hF_FFE7);
    chk("R5 load wins", 32'(burst_addr), 32'hFFFE7);
    step(1'b1, 1'b1, 20'h0);
    chk("R5 data", 32'(rd_data), 32'(word_of(20'hFFFE7)));
  endtask

  task automatic t_gating;
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk("R8 ce off oe", 32'(rd_oe), 32'h0);
    chk("R8 ce off data", 32'(rd_data), 32'h0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R8 oe off data", 32'(rd_data), 32'h0);
    chk("R8 oe off oe", 32'(rd_oe), 32'h0);
    oe_n = 1'b0; #1;
    chk("R8 on", 32'(rd_oe), 32'h1);
    chk("R8 on data", 32'(rd_data), 32'(word_of(20'hFFFE7)));
  endtask

  task automatic t_cycle;
    logic [19:0] exp_a;
    step(1'b0, 1'b1, 20'h8_4411);
    exp_a = 20'h84411;
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b0, 20'h0);
      exp_a = {exp_a[19:5], exp_a[4:0] + 5'd1};
      if (i == 40) chk("R4 mid burst", 32'(burst_addr), 32'(exp_a));
    end
    chk("R9 back to start", 32'(burst_addr), 32'h84411);
  endtask

  initial begin : watchdog
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_wrap();
    t_priority();
    t_gating();
    t_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule